// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block sits on the controller side of a DRAM interface and decides when a refresh must be sent. A fixed number of refresh operations has to land inside each data-retention window. The block divides that window evenly and counts one owed refresh each time an interval expires. The window is long at normal temperature and half as long when the hot input is asserted. A change on the hot input is only picked up at the next interval boundary, so an interval that has already started always runs its full length.

While the controller reports that it is busy, owed refreshes pile up instead of being requested. Once the owed count reaches its ceiling, the block raises an urgent flag and requests a refresh even though busy is still asserted. When the controller is idle, owed refreshes are released one per acknowledge. No more than the ceiling number are released in an unbroken run, and after such a run the request drops for at least one cycle.

Top module: `refresh_sched`

## Requirements
- R1: At normal temperature the refresh interval is CLK_MHZ*WIN_NORM_US/REFS_PER_WIN clock cycles. After reset the first interval expires on the rising edge with that number, counting from the first edge after reset is released.
- R2: While the hot input is sampled high at an interval boundary, the following interval lasts CLK_MHZ*WIN_HOT_US/REFS_PER_WIN cycles. The interval that follows reset always has the normal length, and a change on the hot input takes effect only at the next boundary.
- R3: Each interval expiry adds one to the owed count. Each cycle in which ref_req_o and ref_ack_i are both high removes one, and an expiry and an acknowledge in the same cycle leave the count unchanged.
- R4: With busy_i low, a nonzero owed count and the run limit not reached, ref_req_o is high.
- R5: With busy_i high, ref_req_o stays low until the owed count reaches MAX_OWED. At that count urgent_o is high and ref_req_o is high regardless of busy_i.
- R6: The owed count never exceeds MAX_OWED. Expiries that arrive at the ceiling are dropped, so a single acknowledge from the ceiling clears urgent_o.
- R7: After MAX_OWED acknowledges on consecutive cycles, ref_req_o is low for exactly one cycle. It is then asserted again if refreshes are still owed.
- R8: While rst_i is high, ref_req_o and urgent_o are low, and the owed count and the interval timer are zero.
- R9: With an owed count of zero, ref_req_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| hot_i | input | 1 | High-temperature indication, sampled at interval boundaries |
| busy_i | input | 1 | Controller busy; defers requests that are not urgent |
| ref_ack_i | input | 1 | Refresh accepted in this cycle when ref_req_o is high |
| ref_req_o | output | 1 | Refresh request |
| urgent_o | output | 1 | Owed count is at its ceiling |

## Verification
The assertions assume that ref_ack_i only means something while ref_req_o is high. The owed count moves on req and ack together, so an acknowledge with no request has no effect. They also assume that MAX_OWED is at least two, so that a full run of acknowledges can never coincide with a full owed count. The bench drives ack either high for a known stretch or as a copy of the request sampled half a cycle earlier. Inputs change only at falling edges, and the configuration is scaled down to an 8-cycle normal interval and a 4-cycle hot interval, so every expiry edge can be computed by multiplication.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   // cycles per refresh slot for a window in microseconds
   function automatic int slot_cycles(input int mhz, input int win_us, input int refs);
      return (mhz * win_us) / refs;
   endfunction

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer
   import refsched_pkg::*;
#(
   parameter int INT_NORM   = 8,
   parameter int INT_HOT    = 4,
   parameter bit TEMP_AWARE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic hot_i,
   output logic tick_o
);
   localparam int TW = cnt_width(INT_NORM);
   localparam logic [TW-1:0] LAST_NORM = TW'(INT_NORM - 1);
   localparam logic [TW-1:0] LAST_HOT  = TW'(INT_HOT - 1);

   logic [TW-1:0] count_q;
   logic [TW-1:0] last_w;

   generate
      if (TEMP_AWARE) begin : g_temp
         logic hot_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)       hot_q <= 1'b0;
            else if (tick_o) hot_q <= hot_i;
         end
         assign last_w = hot_q ? LAST_HOT : LAST_NORM;
      end else begin : g_fixed
         logic unused_hot;
         assign unused_hot = hot_i;
         assign last_w = LAST_NORM;
      end
   endgenerate

   assign tick_o = (count_q == last_w);

   always_ff @(posedge clk_i) begin
      if (rst_i)       count_q <= '0;
      else if (tick_o) count_q <= '0;
      else             count_q <= count_q + 1'b1;
   end
endmodule

// File: rtl/refsched_owed.sv
module refsched_owed
   import refsched_pkg::*;
#(
   parameter int MAX_OWED = 8,
   parameter int CW       = cnt_width(MAX_OWED)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tick_i,
   input  logic          take_i,
   output logic [CW-1:0] pend_o,
   output logic          full_o,
   output logic          nz_o
);
   localparam logic [CW-1:0] CEIL = CW'(MAX_OWED);

   logic [CW-1:0] pend_q;

   assign full_o = (pend_q == CEIL);
   assign nz_o   = (pend_q != '0);
   assign pend_o = pend_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= '0;
      end else begin
         unique case ({tick_i, take_i})
            2'b10:   if (!full_o) pend_q <= pend_q + 1'b1;
            2'b01:   if (nz_o)    pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end
endmodule

// File: rtl/refsched_issue.sv
module refsched_issue
   import refsched_pkg::*;
#(
   parameter int MAX_OWED = 8
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic nz_i,
   input  logic full_i,
   input  logic busy_i,
   input  logic ack_i,
   output logic req_o,
   output logic urgent_o
);
   localparam int RW = cnt_width(MAX_OWED);
   localparam logic [RW-1:0] RUN_MAX = RW'(MAX_OWED);

   logic [RW-1:0] run_q;
   logic          cap_w;

   assign cap_w    = (run_q == RUN_MAX);
   assign urgent_o = full_i;
   assign req_o    = nz_i && (!busy_i || full_i) && !cap_w;

   always_ff @(posedge clk_i) begin
      if (rst_i)               run_q <= '0;
      else if (req_o && ack_i) run_q <= run_q + 1'b1;
      else                     run_q <= '0;
   end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
   import refsched_pkg::*;
#(
   parameter int CLK_MHZ      = 400,
   parameter int WIN_NORM_US  = 64000,
   parameter int WIN_HOT_US   = 32000,
   parameter int REFS_PER_WIN = 8192,
   parameter int MAX_OWED     = 8,
   parameter bit TEMP_AWARE   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic hot_i,
   input  logic busy_i,
   input  logic ref_ack_i,
   output logic ref_req_o,
   output logic urgent_o
);
   localparam int INT_NORM = slot_cycles(CLK_MHZ, WIN_NORM_US, REFS_PER_WIN);
   localparam int INT_HOT  = slot_cycles(CLK_MHZ, WIN_HOT_US, REFS_PER_WIN);
   localparam int CW       = cnt_width(MAX_OWED);

   if (INT_NORM < 2) begin : g_bad_norm
      $error("normal refresh interval must be at least two cycles");
   end
   if (TEMP_AWARE && (INT_HOT < 1 || INT_HOT > INT_NORM)) begin : g_bad_hot
      $error("hot interval must be between one cycle and the normal interval");
   end
   if (MAX_OWED < 2) begin : g_bad_owed
      $error("owed ceiling must be at least two");
   end

   logic          tick_w;
   logic          take_w;
   logic          full_w;
   logic          nz_w;
   logic [CW-1:0] pend_w;

   assign take_w = ref_req_o && ref_ack_i;

   refsched_timer #(
      .INT_NORM   (INT_NORM),
      .INT_HOT    (INT_HOT),
      .TEMP_AWARE (TEMP_AWARE)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .hot_i  (hot_i),
      .tick_o (tick_w)
   );

   refsched_owed #(
      .MAX_OWED (MAX_OWED),
      .CW       (CW)
   ) u_owed (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .tick_i (tick_w),
      .take_i (take_w),
      .pend_o (pend_w),
      .full_o (full_w),
      .nz_o   (nz_w)
   );

   refsched_issue #(
      .MAX_OWED (MAX_OWED)
   ) u_issue (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .nz_i     (nz_w),
      .full_i   (full_w),
      .busy_i   (busy_i),
      .ack_i    (ref_ack_i),
      .req_o    (ref_req_o),
      .urgent_o (urgent_o)
   );
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
   parameter int MAX_OWED = 8,
   parameter int CW       = 4
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          busy_i,
   input logic          ack_i,
   input logic          req_i,
   input logic          urgent_i,
   input logic          tick_i,
   input logic [CW-1:0] pend_i
);
   localparam logic [CW-1:0] CEIL = CW'(MAX_OWED);

   // independent count of consecutive accepted refreshes
   logic [CW-1:0] run_c;
   logic          rst_seen;
   always_ff @(posedge clk_i) begin
      rst_seen <= rst_i;
      if (rst_i)               run_c <= '0;
      else if (req_i && ack_i) run_c <= run_c + 1'b1;
      else                     run_c <= '0;
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      pend_i <= CEIL);

   // R5
   urgent_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (urgent_i && run_c != CEIL) |-> req_i);

   // R5
   defer_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_i && !urgent_i) |-> !req_i);

   // R9
   idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend_i == '0) |-> !req_i);

   // R3
   take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_i && ack_i && !tick_i) |=> (pend_i == $past(pend_i) - 1'b1));

   // R7
   burst_cap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_c == CEIL) |-> !req_i);

   // R4
   ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busy_i && pend_i != '0 && run_c != CEIL) |-> req_i);

   // R8
   always_ff @(posedge clk_i) begin
      if (rst_seen && rst_i) begin
         reset_state_chk: assert (pend_i == '0 && !req_i && !urgent_i);
      end
   end
endmodule

bind refresh_sched refsched_chk #(
   .MAX_OWED (MAX_OWED),
   .CW       (CW)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .busy_i   (busy_i),
   .ack_i    (ref_ack_i),
   .req_i    (ref_req_o),
   .urgent_i (urgent_o),
   .tick_i   (tick_w),
   .pend_i   (pend_w)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
   // scaled config: normal slot = 1*64/8 = 8 cycles, hot slot = 1*32/8 = 4
   localparam int MHZ  = 1;
   localparam int WN   = 64;
   localparam int WH   = 32;
   localparam int REFS = 8;
   localparam int OWED = 8;
   localparam int TN   = MHZ * WN / REFS;
   localparam int TH   = MHZ * WH / REFS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hot = 1'b0;
   logic busy = 1'b0;
   logic ack = 1'b0;
   logic req;
   logic urgent;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int acks = 0;

   always #5 clk = ~clk;

   refresh_sched #(
      .CLK_MHZ      (MHZ),
      .WIN_NORM_US  (WN),
      .WIN_HOT_US   (WH),
      .REFS_PER_WIN (REFS),
      .MAX_OWED     (OWED),
      .TEMP_AWARE   (1'b1)
   ) uut (
      .clk_i     (clk),
      .rst_i     (rst),
      .hot_i     (hot),
      .busy_i    (busy),
      .ref_ack_i (ack),
      .ref_req_o (req),
      .urgent_o  (urgent)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   task automatic step(input bit auto_ack);
      if (ack && req) acks++;
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (auto_ack) ack = req;
   endtask

   task automatic go_to(input int n, input bit auto_ack);
      while (cyc < n) step(auto_ack);
   endtask

   task automatic do_reset(input bit hot_v, input bit busy_v);
      @(negedge clk);
      rst = 1'b1;
      ack = 1'b0;
      hot = hot_v;
      busy = busy_v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8 outputs idle while reset is held
      check(req == 1'b0 && urgent == 1'b0, "R8 reset outputs", {req, urgent}, 0);
      rst = 1'b0;
      cyc = 0;
      acks = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 / R4 / R3 / R9: idle controller, normal temperature
      do_reset(1'b0, 1'b0);
      go_to(TN - 1, 1'b0);
      check(req == 1'b0, "R1 no request before first expiry", req, 0);
      go_to(TN, 1'b0);
      check(req == 1'b1, "R1 R4 request at first expiry", req, 1);
      check(urgent == 1'b0, "R5 not urgent with one owed", urgent, 0);
      ack = 1'b1;
      step(1'b0);
      ack = 1'b0;
      check(req == 1'b0, "R3 R9 one ack clears single owed refresh", req, 0);

      // R5 / R6: busy defers until ceiling; saturation
      do_reset(1'b0, 1'b1);
      go_to(OWED * TN - 1, 1'b0);
      check(req == 1'b0 && urgent == 1'b0, "R5 deferred while busy", {req, urgent}, 0);
      go_to(OWED * TN, 1'b0);
      check(urgent == 1'b1, "R5 urgent at ceiling", urgent, 1);
      check(req == 1'b1, "R5 request despite busy", req, 1);
      go_to(OWED * TN + 2 * TN, 1'b0);
      check(urgent == 1'b1 && req == 1'b1, "R6 still urgent past ceiling", {req, urgent}, 3);
      ack = 1'b1;
      step(1'b0);
      ack = 1'b0;
      check(urgent == 1'b0, "R6 single ack leaves count below ceiling", urgent, 0);
      check(req == 1'b0, "R5 busy defers again below ceiling", req, 0);

      // R7 / R3: run limit after a full backlog
      do_reset(1'b0, 1'b1);
      go_to(OWED * TN, 1'b0);
      busy = 1'b0;
      ack = 1'b1;
      acks = 0;
      go_to(OWED * TN + OWED - 1, 1'b0);
      check(req == 1'b1, "R4 backlog still requested", req, 1);
      step(1'b0);
      check(req == 1'b0, "R7 request dropped after full run", req, 0);
      step(1'b0);
      check(req == 1'b1, "R7 request back after one-cycle gap", req, 1);
      step(1'b0);
      check(req == 1'b0, "R9 nothing owed after drain", req, 0);
      check(acks == OWED + 1, "R3 accepted refresh count", acks, OWED + 1);
      ack = 1'b0;

      // R2: hot interval starting at the next boundary, then back to normal
      do_reset(1'b1, 1'b0);
      go_to(TN - 1, 1'b1);
      check(req == 1'b0, "R2 first interval is normal length", req, 0);
      go_to(TN, 1'b1);
      check(req == 1'b1, "R2 first expiry at normal length", req, 1);
      go_to(TN + TH - 1, 1'b1);
      check(req == 1'b0, "R2 before hot expiry", req, 0);
      go_to(TN + TH, 1'b1);
      check(req == 1'b1, "R2 hot expiry", req, 1);
      acks = 0;
      go_to(TN + 8 * TH + 1, 1'b1);
      check(acks == 8, "R2 R3 refreshes over eight hot slots", acks, 8);
      hot = 1'b0;
      go_to(TN + 9 * TH - 1, 1'b1);
      check(req == 1'b0, "R2 change waits for boundary", req, 0);
      go_to(TN + 9 * TH, 1'b1);
      check(req == 1'b1, "R2 current hot slot completes", req, 1);
      go_to(TN + 9 * TH + TN - 1, 1'b1);
      check(req == 1'b0, "R1 normal slot resumes", req, 0);
      go_to(TN + 9 * TH + TN, 1'b1);
      check(req == 1'b1, "R1 normal expiry after cooling", req, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule